// File: doc/BRIEF.md
# Secure Grouped Interrupt Acknowledge Gate

This block sits between an interrupt selector and one processor. Each cycle the selector presents its best pending interrupt: an ID and a one-bit group, where group 0 is the secure group and group 1 is the non-secure group. The gate drives the processor's IRQ and FIQ lines for that interrupt. It answers acknowledge requests with the ID to service, and it accepts or refuses end-of-interrupt requests. Every request carries a secure or non-secure attribute, and the result depends on that attribute, on the interrupt's group and on the bits of a small banked control register.

The gate also keeps a hold state machine with two states, OPEN and BUSY. An accepted acknowledge takes the interrupt (OPEN to BUSY, or BUSY to BUSY when a different interrupt is taken). While BUSY, the taken ID is masked from the lines, so an acknowledged interrupt is never signalled again. The release transition (BUSY to OPEN) fires when one of three things happens: an accepted end-of-interrupt names the held ID, the selector stops presenting that ID, or the selector drops its valid flag.

Control register, secure view: bit 0 enables group 0, bit 1 enables group 1, bit 2 lets a secure requester acknowledge group 1, and bit 3 sends group 0 out on FIQ. The non-secure view shows only the group 1 enable, at bit 0.

Top module: `sec_ack_gate`

## Requirements
- R1: During and after reset, irq, fiq, ack_vld and eoi_done are low, ack_id is zero and the control register is zero.
- R2: An eligible interrupt is one that is valid, whose group is enabled, and that is not masked by the hold. An eligible group 0 interrupt drives fiq when control bit 3 is set and drives irq when it is clear. An eligible group 1 interrupt always drives irq. A disabled group drives neither line, and irq and fiq are never high together.
- R3: A secure acknowledge of an eligible group 0 interrupt returns its ID. A non-secure acknowledge of a group 0 interrupt returns 1023.
- R4: A non-secure acknowledge of an eligible group 1 interrupt returns its ID. A secure acknowledge returns the ID when control bit 2 is set, and returns 1022 when it is clear.
- R5: A refused acknowledge (result 1022 or 1023) leaves the hold state unchanged, so the line stays asserted.
- R6: An acknowledge with no eligible interrupt returns 1023. This covers an invalid input, a disabled group and a held ID.
- R7: After an accepted acknowledge, both lines are low while the selector keeps presenting the taken ID. When the selector presents a different eligible ID, the line rises again.
- R8: An end-of-interrupt is accepted only if it is secure or names group 1. An accepted request gives a one-cycle eoi_done pulse; a refused request gives none.
- R9: An accepted end-of-interrupt naming the held ID releases the hold. If that ID is still presented, its line rises again.
- R10: A secure write loads all four control bits. A non-secure write changes only the group 1 enable, taken from data bit 0. A secure read returns the four bits; a non-secure read returns the group 1 enable at bit 0 and zero in bits 3:1.
- R11: ack_vld is a one-cycle pulse on the cycle after each acknowledge request, and ack_id is zero whenever ack_vld is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_valid | input | 1 | Selector presents an interrupt |
| pend_id | input | ID_W | Presented interrupt ID |
| pend_grp | input | 1 | Presented interrupt group (1 = non-secure group) |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_sec | input | 1 | Write is secure |
| ctl_wr_data | input | 4 | Write data |
| ctl_rd_sec | input | 1 | Read view selector (1 = secure view) |
| ctl_rd_data | output | 4 | Control register in the selected view |
| ack_req | input | 1 | Acknowledge request |
| ack_sec | input | 1 | Acknowledge is secure |
| ack_vld | output | 1 | Acknowledge result valid |
| ack_id | output | ID_W | Acknowledge result ID |
| eoi_req | input | 1 | End-of-interrupt request |
| eoi_sec | input | 1 | End-of-interrupt is secure |
| eoi_id | input | ID_W | ID being completed |
| eoi_grp | input | 1 | Group of the ID being completed |
| eoi_done | output | 1 | Completion accepted pulse |
| irq | output | 1 | Interrupt line |
| fiq | output | 1 | Fast interrupt line |

## Verification
Results are due at these times, counted from the rising edge that samples a request:
- ack_vld, ack_id and eoi_done are due one edge later.
- irq and fiq for the inputs and hold state at an edge are due right after that edge. They are built from the hold state the edge produces, so a taken interrupt drops in the same cycle that its ack_vld rises.
- ctl_rd_data follows the register with no delay. A control write reaches the lines one edge after it is stored.

The bench updates its reference model just after each rising edge, using the inputs that edge sampled. It compares every output at the following falling edge. Stimulus changes only after that comparison, so every expected value applies to exactly one edge.

// File: rtl/sag_pkg.sv
package sag_pkg;

    typedef enum logic [0:0] {
        HOLD_OPEN = 1'b0,
        HOLD_BUSY = 1'b1
    } hold_e;

    // secure layout, LSB first: g0_en, g1_en, ack_ctl, fiq_en
    typedef struct packed {
        logic fiq_en;
        logic ack_ctl;
        logic g1_en;
        logic g0_en;
    } gate_ctl_t;

    localparam int CTL_W = $bits(gate_ctl_t);

endpackage

// File: rtl/sag_ctl_reg.sv
module sag_ctl_reg
    import sag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sec,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             rd_sec,
    output logic [CTL_W-1:0] rd_data,
    output gate_ctl_t        ctl
);

    gate_ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            if (wr_sec) begin
                ctl_q <= gate_ctl_t'(wr_data);
            end else begin
                // non-secure side reaches only its own enable
                ctl_q.g1_en <= wr_data[0];
            end
        end
    end

    always_comb begin
        if (rd_sec) begin
            rd_data = ctl_q;
        end else begin
            rd_data = {{(CTL_W-1){1'b0}}, ctl_q.g1_en};
        end
    end

    assign ctl = ctl_q;

endmodule

// File: rtl/sag_ack_fsm.sv
module sag_ack_fsm
    import sag_pkg::*;
#(
    parameter int ID_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pend_valid,
    input  logic [ID_W-1:0] pend_id,
    input  logic            pend_grp,
    input  logic            g0_en,
    input  logic            g1_en,
    input  logic            ack_ctl,
    input  logic            ack_req,
    input  logic            ack_sec,
    input  logic            eoi_req,
    input  logic            eoi_sec,
    input  logic [ID_W-1:0] eoi_id,
    input  logic            eoi_grp,
    output logic            ack_vld,
    output logic [ID_W-1:0] ack_id,
    output logic            eoi_done,
    output hold_e           hold_nxt,
    output logic [ID_W-1:0] held_id_nxt
);

    localparam logic [ID_W-1:0] ID_SPUR = {ID_W{1'b1}};
    localparam logic [ID_W-1:0] ID_GRP1 = {{(ID_W-1){1'b1}}, 1'b0};

    hold_e           state_q;
    logic [ID_W-1:0] held_q;
    logic            grp_en;
    logic            live;
    logic            take;
    logic            eoi_ok;
    logic            drop;
    logic [ID_W-1:0] ack_res;
    logic            ack_vld_q;
    logic [ID_W-1:0] ack_id_q;
    logic            eoi_done_q;

    always_comb begin
        grp_en = pend_grp ? g1_en : g0_en;
        live   = pend_valid && grp_en &&
                 !((state_q == HOLD_BUSY) && (pend_id == held_q));
        take   = ack_req && live && (pend_grp ? (!ack_sec || ack_ctl) : ack_sec);
        eoi_ok = eoi_req && (eoi_grp || eoi_sec);
        drop   = (eoi_ok && (eoi_id == held_q)) || !pend_valid || (pend_id != held_q);

        if (!live) begin
            ack_res = ID_SPUR;
        end else if (take) begin
            ack_res = pend_id;
        end else if (pend_grp && ack_sec) begin
            ack_res = ID_GRP1;
        end else begin
            ack_res = ID_SPUR;
        end
    end

    // next-state decode: take, retake, release
    always_comb begin
        hold_nxt    = state_q;
        held_id_nxt = held_q;
        unique case (state_q)
            HOLD_OPEN: begin
                if (take) begin
                    hold_nxt    = HOLD_BUSY;
                    held_id_nxt = pend_id;
                end
            end
            HOLD_BUSY: begin
                if (take) begin
                    held_id_nxt = pend_id;
                end else if (drop) begin
                    hold_nxt = HOLD_OPEN;
                end
            end
            default: hold_nxt = HOLD_OPEN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HOLD_OPEN;
            held_q  <= '0;
        end else begin
            state_q <= hold_nxt;
            held_q  <= held_id_nxt;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_vld_q  <= 1'b0;
            ack_id_q   <= '0;
            eoi_done_q <= 1'b0;
        end else begin
            ack_vld_q  <= ack_req;
            ack_id_q   <= ack_req ? ack_res : '0;
            eoi_done_q <= eoi_ok;
        end
    end

    assign ack_vld  = ack_vld_q;
    assign ack_id   = ack_id_q;
    assign eoi_done = eoi_done_q;

endmodule

// File: rtl/sag_line_router.sv
module sag_line_router
    import sag_pkg::*;
#(
    parameter int ID_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pend_valid,
    input  logic [ID_W-1:0] pend_id,
    input  logic            pend_grp,
    input  logic            g0_en,
    input  logic            g1_en,
    input  logic            fiq_en,
    input  hold_e           hold_nxt,
    input  logic [ID_W-1:0] held_id_nxt,
    output logic            irq,
    output logic            fiq
);

    logic elig;
    logic irq_q;
    logic fiq_q;

    // the next hold state masks a just-taken ID at the same edge
    always_comb begin
        elig = pend_valid && (pend_grp ? g1_en : g0_en) &&
               !((hold_nxt == HOLD_BUSY) && (pend_id == held_id_nxt));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
        end else begin
            irq_q <= elig && (pend_grp || !fiq_en);
            fiq_q <= elig && !pend_grp && fiq_en;
        end
    end

    assign irq = irq_q;
    assign fiq = fiq_q;

endmodule

// File: rtl/sec_ack_gate.sv
module sec_ack_gate
    import sag_pkg::*;
#(
    parameter int ID_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pend_valid,
    input  logic [ID_W-1:0] pend_id,
    input  logic            pend_grp,
    input  logic            ctl_wr_en,
    input  logic            ctl_wr_sec,
    input  logic [3:0]      ctl_wr_data,
    input  logic            ctl_rd_sec,
    output logic [3:0]      ctl_rd_data,
    input  logic            ack_req,
    input  logic            ack_sec,
    output logic            ack_vld,
    output logic [ID_W-1:0] ack_id,
    input  logic            eoi_req,
    input  logic            eoi_sec,
    input  logic [ID_W-1:0] eoi_id,
    input  logic            eoi_grp,
    output logic            eoi_done,
    output logic            irq,
    output logic            fiq
);

    gate_ctl_t       gate_ctl;
    hold_e           hold_nxt;
    logic [ID_W-1:0] held_id_nxt;

    sag_ctl_reg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr_en),
        .wr_sec  (ctl_wr_sec),
        .wr_data (ctl_wr_data),
        .rd_sec  (ctl_rd_sec),
        .rd_data (ctl_rd_data),
        .ctl     (gate_ctl)
    );

    sag_ack_fsm #(.ID_W(ID_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_valid  (pend_valid),
        .pend_id     (pend_id),
        .pend_grp    (pend_grp),
        .g0_en       (gate_ctl.g0_en),
        .g1_en       (gate_ctl.g1_en),
        .ack_ctl     (gate_ctl.ack_ctl),
        .ack_req     (ack_req),
        .ack_sec     (ack_sec),
        .eoi_req     (eoi_req),
        .eoi_sec     (eoi_sec),
        .eoi_id      (eoi_id),
        .eoi_grp     (eoi_grp),
        .ack_vld     (ack_vld),
        .ack_id      (ack_id),
        .eoi_done    (eoi_done),
        .hold_nxt    (hold_nxt),
        .held_id_nxt (held_id_nxt)
    );

    sag_line_router #(.ID_W(ID_W)) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_valid  (pend_valid),
        .pend_id     (pend_id),
        .pend_grp    (pend_grp),
        .g0_en       (gate_ctl.g0_en),
        .g1_en       (gate_ctl.g1_en),
        .fiq_en      (gate_ctl.fiq_en),
        .hold_nxt    (hold_nxt),
        .held_id_nxt (held_id_nxt),
        .irq         (irq),
        .fiq         (fiq)
    );

endmodule

// File: rtl/sec_ack_gate_chk.sv
module sec_ack_gate_chk #(
    parameter int ID_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pend_valid,
    input logic [ID_W-1:0] pend_id,
    input logic            pend_grp,
    input logic            g1_en,
    input logic            ack_ctl,
    input logic            ack_req,
    input logic            ack_sec,
    input logic            ack_vld,
    input logic [ID_W-1:0] ack_id,
    input logic            eoi_req,
    input logic            eoi_sec,
    input logic            eoi_grp,
    input logic            eoi_done,
    input logic            irq,
    input logic            fiq
);

    localparam logic [ID_W-1:0] ID_SPUR = {ID_W{1'b1}};
    localparam logic [ID_W-1:0] ID_GRP1 = {{(ID_W-1){1'b1}}, 1'b0};

    // R2
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && fiq));

    // R3
    ns_grp0_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req && !ack_sec && pend_valid && !pend_grp |=> ack_vld && (ack_id == ID_SPUR));

    // R4
    sec_grp1_noctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req && ack_sec && pend_valid && pend_grp && g1_en && !ack_ctl
        |=> ack_vld && ((ack_id == ID_GRP1) || (ack_id == ID_SPUR)));

    // R7
    acked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld && (ack_id < ID_GRP1) && $past(pend_valid) && ($past(pend_id) == ack_id)
        |-> !irq && !fiq);

    // R8
    ns_grp0_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_req && !eoi_sec && !eoi_grp |=> !eoi_done);

    // R11
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_vld);

    // R11
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_req |=> !ack_vld && (ack_id == '0));

endmodule

bind sec_ack_gate sec_ack_gate_chk #(.ID_W(ID_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_valid (pend_valid),
    .pend_id    (pend_id),
    .pend_grp   (pend_grp),
    .g1_en      (gate_ctl.g1_en),
    .ack_ctl    (gate_ctl.ack_ctl),
    .ack_req    (ack_req),
    .ack_sec    (ack_sec),
    .ack_vld    (ack_vld),
    .ack_id     (ack_id),
    .eoi_req    (eoi_req),
    .eoi_sec    (eoi_sec),
    .eoi_grp    (eoi_grp),
    .eoi_done   (eoi_done),
    .irq        (irq),
    .fiq        (fiq)
);

// File: tb/sec_ack_gate_tb.sv
module sec_ack_gate_tb;

    localparam int ID_W = 10;
    localparam int SPUR = 1023;
    localparam int GRP1 = 1022;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pend_valid = 1'b0;
    logic [ID_W-1:0] pend_id = '0;
    logic            pend_grp = 1'b0;
    logic            ctl_wr_en = 1'b0;
    logic            ctl_wr_sec = 1'b0;
    logic [3:0]      ctl_wr_data = '0;
    logic            ctl_rd_sec = 1'b1;
    logic [3:0]      ctl_rd_data;
    logic            ack_req = 1'b0;
    logic            ack_sec = 1'b0;
    logic            ack_vld;
    logic [ID_W-1:0] ack_id;
    logic            eoi_req = 1'b0;
    logic            eoi_sec = 1'b0;
    logic [ID_W-1:0] eoi_id = '0;
    logic            eoi_grp = 1'b0;
    logic            eoi_done;
    logic            irq;
    logic            fiq;

    always #2.5 clk = ~clk;

    sec_ack_gate #(.ID_W(ID_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .pend_valid(pend_valid), .pend_id(pend_id), .pend_grp(pend_grp),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_sec(ctl_wr_sec), .ctl_wr_data(ctl_wr_data),
        .ctl_rd_sec(ctl_rd_sec), .ctl_rd_data(ctl_rd_data),
        .ack_req(ack_req), .ack_sec(ack_sec), .ack_vld(ack_vld), .ack_id(ack_id),
        .eoi_req(eoi_req), .eoi_sec(eoi_sec), .eoi_id(eoi_id), .eoi_grp(eoi_grp),
        .eoi_done(eoi_done), .irq(irq), .fiq(fiq)
    );

    int n_vec  = 0;
    int n_miss = 0;
    bit finished = 1'b0;

    // behavioural reference state
    bit m_g0, m_g1, m_ac, m_fq;
    bit m_held;
    int m_hid;
    bit m_irq, m_fiq, m_av, m_ed;
    int m_aid;

    function automatic void model_reset();
        m_g0 = 0; m_g1 = 0; m_ac = 0; m_fq = 0;
        m_held = 0; m_hid = 0;
        m_irq = 0; m_fiq = 0; m_av = 0; m_ed = 0; m_aid = 0;
    endfunction

    function automatic void model_step();
        bit en, live, ok, eok, live2;
        int pid, res;
        pid  = int'(pend_id);
        en   = pend_grp ? m_g1 : m_g0;
        live = pend_valid && en && !(m_held && pid == m_hid);
        ok   = 0;
        res  = SPUR;
        if (live) begin
            if (!pend_grp) begin
                if (ack_sec) begin ok = 1; res = pid; end
            end else if (!ack_sec || m_ac) begin
                ok = 1; res = pid;
            end else begin
                res = GRP1;
            end
        end
        ok  = ok && ack_req;
        eok = eoi_req && (eoi_grp || eoi_sec);
        if (ok) begin
            m_held = 1; m_hid = pid;
        end else if (m_held && ((eok && int'(eoi_id) == m_hid) || !pend_valid || pid != m_hid)) begin
            m_held = 0;
        end
        live2 = pend_valid && en && !(m_held && pid == m_hid);
        m_irq = live2 && (pend_grp || !m_fq);
        m_fiq = live2 && !pend_grp && m_fq;
        m_av  = ack_req;
        m_aid = ack_req ? res : 0;
        m_ed  = eok;
        if (ctl_wr_en) begin
            if (ctl_wr_sec) begin
                m_g0 = ctl_wr_data[0]; m_g1 = ctl_wr_data[1];
                m_ac = ctl_wr_data[2]; m_fq = ctl_wr_data[3];
            end else begin
                m_g1 = ctl_wr_data[0];
            end
        end
    endfunction

    function automatic void chk(string tag, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_miss++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endfunction

    function automatic void check_all(string tag);
        int rd_exp;
        rd_exp = ctl_rd_sec ? {m_fq, m_ac, m_g1, m_g0} : {3'b000, m_g1};
        chk(tag, "irq", int'(irq), int'(m_irq));
        chk(tag, "fiq", int'(fiq), int'(m_fiq));
        chk(tag, "ack_vld", int'(ack_vld), int'(m_av));
        chk(tag, "ack_id", int'(ack_id), m_aid);
        chk(tag, "eoi_done", int'(eoi_done), int'(m_ed));
        chk(tag, "ctl_rd_data", int'(ctl_rd_data), rd_exp);
    endfunction

    task automatic cyc(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all(tag);
        ack_req   = 0;
        eoi_req   = 0;
        ctl_wr_en = 0;
    endtask

    task automatic wr_ctl(input bit sec, input logic [3:0] d, input string tag);
        ctl_wr_en = 1; ctl_wr_sec = sec; ctl_wr_data = d;
        cyc(tag);
    endtask

    task automatic ack(input bit sec, input string tag);
        ack_req = 1; ack_sec = sec;
        cyc(tag);
    endtask

    task automatic eoi(input bit sec, input int id, input bit grp, input string tag);
        eoi_req = 1; eoi_sec = sec; eoi_id = ID_W'(id); eoi_grp = grp;
        cyc(tag);
    endtask

    task automatic present(input bit v, input int id, input bit grp);
        pend_valid = v; pend_id = ID_W'(id); pend_grp = grp;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_vec++;
            n_miss++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1;
        cyc("R1");

        // control register views
        wr_ctl(1, 4'b0011, "R10");
        ctl_rd_sec = 0; cyc("R10");
        ctl_rd_sec = 1;

        // group 0 routing
        present(1, 5, 0);
        cyc("R2"); cyc("R2");
        wr_ctl(1, 4'b1011, "R2");
        cyc("R2");

        // group 0 acknowledge rules
        ack(0, "R3");
        cyc("R5");
        ack(1, "R3");
        cyc("R7"); cyc("R7");
        ack(1, "R6");

        // group 0 completion rules
        eoi(0, 5, 0, "R8");
        cyc("R8");
        eoi(1, 5, 0, "R9");
        cyc("R9");

        // group 1 acknowledge rules
        present(1, 40, 1);
        cyc("R2");
        ack(1, "R4");
        cyc("R5");
        ack(0, "R4");
        cyc("R7");
        present(1, 41, 1);
        cyc("R7");
        wr_ctl(1, 4'b1111, "R10");
        cyc("R11");
        ack(1, "R4");
        cyc("R11");
        eoi(0, 41, 1, "R8");
        cyc("R9");

        // non-secure writes touch only the group 1 enable
        ctl_rd_sec = 0;
        wr_ctl(0, 4'b1110, "R10");
        ctl_rd_sec = 1;
        cyc("R10");
        cyc("R2");
        ack(0, "R6");
        wr_ctl(0, 4'b0001, "R10");
        cyc("R2");

        // nothing presented
        present(0, 0, 0);
        cyc("R2");
        ack(1, "R6");
        ack(0, "R6");

        // group 0 with FIQ routing off again
        present(1, 7, 0);
        wr_ctl(1, 4'b0011, "R10");
        cyc("R2");
        ack(1, "R3");
        present(1, 9, 0);
        cyc("R7");
        cyc("R11");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule